// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block is the home-node directory engine for a line-grained invalidation protocol that spans a set of processors. It takes coherence requests of three kinds, each tagged with the requesting processor and the line it targets. For every line it keeps a directory entry with three parts: the processor that last held the line exclusively, one sharer bit per processor, and a flag telling whether home's own copy of the data is current.

The requests are a plain read, an exclusive read, and an upgrade from shared to exclusive. For each one the block sends a short series of abstract messages on a valid/ready output channel. These are invalidations to the other holders, followed by one final message: a data reply from home, a forward to the owner, or a data-free grant. It then rewrites the directory entry. Home's copy can stay stale while several processors share the line (dirty sharing). In that case reads are forwarded to the owner and nothing is written back.

The block serves one request at a time. It stops accepting new requests from the moment it takes one until that request's final message has been taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `out_valid` is 0. Every line starts with home data current and an empty sharer set, so the first read of any line gets a data reply from home.
- R2: `req_kind` is decoded as follows: 0 is a read, 2 is an upgrade, and 1 or 3 is an exclusive read.
- R3: Every message carries a kind in `out_kind`, a destination in `out_dst`, the original requester in `out_req` and the line in `out_line`. The kinds are 0 data reply from home, 1 forward for a read, 2 forward for an exclusive read, 3 invalidation and 4 grant without data. Data replies and grants go to the requester; forwards go to the owner.
- R4: A read is answered in one of three ways. If home data is current, home sends a data reply. If the requester is itself the owner, it gets a grant. Otherwise the request is forwarded to the owner with kind 1. The read then adds the requester to the sharer set and leaves the owner and the home flag unchanged.
- R5: An exclusive read invalidates every sharer except the requester. When the request is forwarded, the owner is also spared an invalidation, because the forward itself hands it the request. The final message follows the same choice as R4, except that the forward has kind 2. Afterwards the requester is the only sharer and the owner, and home's copy is stale.
- R6: An upgrade from a processor already in the sharer set invalidates every other sharer, the owner included. It then sends a grant to the requester and updates the directory as in R5.
- R7: An upgrade from a processor that is not in the sharer set is handled exactly as an exclusive read.
- R8: Invalidations go out one per output handshake, in ascending processor order, and all of them come before the final message. They never go to the requester.
- R9: `req_ready` drops on the cycle after a request is accepted and stays low until the final message's handshake. It is high again, with `out_valid` low, in the cycle after that handshake.
- R10: While `out_valid` is high and `out_ready` is low, all message fields hold steady.
- R11: A read served by a forward leaves home's copy stale, so later reads of the same line are also forwarded to the owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting a request |
| req_kind | input | 2 | Request kind (R2) |
| req_src | input | clog2(NPROC) | Requesting processor |
| req_line | input | clog2(NLINES) | Target line |
| out_valid | output | 1 | Message present |
| out_ready | input | 1 | Message taken |
| out_kind | output | 3 | Message kind (R3) |
| out_dst | output | clog2(NPROC) | Destination processor |
| out_req | output | clog2(NPROC) | Original requester |
| out_line | output | clog2(NLINES) | Line concerned |

## Verification
The bench looks for two places where events overlap in time. The first is the directory write at the end of one request meeting the directory read of the next request on the same line. The bench provokes this by issuing requests back to back on a handful of lines, so each lookup reads an entry that was rewritten only a couple of cycles earlier. The second is a stalled message on the output channel meeting an invalidation series that is still pending. Random `out_ready` gaps are applied during long invalidation runs to provoke it. A behavioural model predicts every message, and the bench checks stalled fields for stability and the busy window for a low `req_ready` on every clock.

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl #(
  parameter int NPROC  = 8,
  parameter int NLINES = 64,
  localparam int PW = $clog2(NPROC),
  localparam int LW = $clog2(NLINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [PW-1:0] req_src,
  input  logic [LW-1:0] req_line,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [2:0]    out_kind,
  output logic [PW-1:0] out_dst,
  output logic [PW-1:0] out_req,
  output logic [LW-1:0] out_line
);

  localparam logic [2:0] K_DATA  = 3'd0;
  localparam logic [2:0] K_FWDRD = 3'd1;
  localparam logic [2:0] K_FWDEX = 3'd2;
  localparam logic [2:0] K_INV   = 3'd3;
  localparam logic [2:0] K_GRANT = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_INV, S_REPLY} state_t;

  state_t            state;
  logic [NPROC-1:0]  sh_q  [NLINES];
  logic [PW-1:0]     own_q [NLINES];
  logic [NLINES-1:0] hv_q;

  logic [PW-1:0]    c_src, c_dst;
  logic [LW-1:0]    c_line;
  logic [2:0]       c_kind;
  logic             c_excl;
  logic [NPROC-1:0] pend;

  function automatic logic [PW-1:0] low_idx(input logic [NPROC-1:0] v);
    low_idx = '0;
    for (int i = NPROC - 1; i >= 0; i--)
      if (v[i]) low_idx = PW'(i);
  endfunction

  logic [NPROC-1:0] e_sh, src_bit, own_bit, inv_mask, pend_next;
  logic [PW-1:0]    e_own, rep_dst, inv_dst;
  logic             e_hv, is_rd, up_hit, self_own, fwd_ex;
  logic [2:0]       rep_kind;
  logic             acc, fire;

  assign e_sh     = sh_q[req_line];
  assign e_own    = own_q[req_line];
  assign e_hv     = hv_q[req_line];
  assign src_bit  = NPROC'(1) << req_src;
  assign own_bit  = NPROC'(1) << e_own;
  assign is_rd    = (req_kind == 2'd0);
  assign up_hit   = (req_kind == 2'd2) && ((e_sh & src_bit) != '0);
  assign self_own = !e_hv && (e_own == req_src);
  assign fwd_ex   = !is_rd && !up_hit && !e_hv && !self_own;

  always_comb begin
    if (up_hit || (!e_hv && self_own)) rep_kind = K_GRANT;
    else if (e_hv)                     rep_kind = K_DATA;
    else if (is_rd)                    rep_kind = K_FWDRD;
    else                               rep_kind = K_FWDEX;
  end

  assign rep_dst   = (rep_kind == K_FWDRD || rep_kind == K_FWDEX) ? e_own : req_src;
  assign inv_mask  = is_rd ? '0 : (e_sh & ~src_bit & ~(fwd_ex ? own_bit : '0));
  assign inv_dst   = low_idx(pend);
  assign pend_next = pend & ~(NPROC'(1) << inv_dst);

  assign req_ready = (state == S_IDLE);
  assign out_valid = (state != S_IDLE);
  assign out_kind  = (state == S_INV) ? K_INV : c_kind;
  assign out_dst   = (state == S_INV) ? inv_dst : c_dst;
  assign out_req   = c_src;
  assign out_line  = c_line;
  assign acc       = req_valid && req_ready;
  assign fire      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      c_src  <= '0;
      c_dst  <= '0;
      c_line <= '0;
      c_kind <= K_DATA;
      c_excl <= 1'b0;
      pend   <= '0;
      hv_q   <= '1;
      for (int i = 0; i < NLINES; i++) begin
        sh_q[i]  <= '0;
        own_q[i] <= '0;
      end
    end else begin
      case (state)
        S_IDLE: if (acc) begin
          c_src  <= req_src;
          c_line <= req_line;
          c_kind <= rep_kind;
          c_dst  <= rep_dst;
          c_excl <= !is_rd;
          pend   <= inv_mask;
          state  <= (inv_mask != '0) ? S_INV : S_REPLY;
        end
        S_INV: if (fire) begin
          pend <= pend_next;
          if (pend_next == '0) state <= S_REPLY;
        end
        default: if (fire) begin
          state <= S_IDLE;
          if (c_excl) begin
            sh_q[c_line]  <= NPROC'(1) << c_src;
            own_q[c_line] <= c_src;
            hv_q[c_line]  <= 1'b0;
          end else begin
            sh_q[c_line]  <= sh_q[c_line] | (NPROC'(1) << c_src);
          end
        end
      endcase
    end
  end

  a_r8_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind == K_INV) |=>
      (out_valid && (out_kind != K_INV || out_dst > $past(out_dst))));

  a_r8_inv_not_requester: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_INV) |-> (out_dst != out_req));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_kind) && $stable(out_dst) && $stable(out_req) && $stable(out_line)));

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (out_valid && !req_ready));

  a_r9_ready_after_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_kind != K_INV) |=> (req_ready && !out_valid));

  a_r3_forward_not_self: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_kind == K_FWDRD || out_kind == K_FWDEX)) |-> (out_dst != out_req));

endmodule

// File: tb/dir_home_ctrl_test.sv
module dir_home_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 8;
  localparam int NL = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       req_valid = 1'b0, out_ready = 1'b0;
  logic       req_ready, out_valid;
  logic [1:0] req_kind = '0;
  logic [2:0] req_src = '0, out_dst, out_req;
  logic [5:0] req_line = '0, out_line;
  logic [2:0] out_kind;

  dir_home_ctrl #(.NPROC(NP), .NLINES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_src(req_src), .req_line(req_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
    .out_dst(out_dst), .out_req(out_req), .out_line(out_line));

  int checks = 0;
  int fails = 0;
  bit stall_en = 0;

  logic [NP-1:0] m_sh [NL];
  int            m_own [NL];
  bit            m_hv [NL];
  int            exp_q[$];
  string         tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic model(input int k, input int s, input int l);
    bit rd, hit, self;
    int rk, rdst;
    string t;
    rd   = (k == 0);
    hit  = (k == 2) && m_sh[l][s];
    self = !m_hv[l] && (m_own[l] == s);
    if (hit)          begin rk = 4; rdst = s; end
    else if (m_hv[l]) begin rk = 0; rdst = s; end
    else if (self)    begin rk = 4; rdst = s; end
    else if (rd)      begin rk = 1; rdst = m_own[l]; end
    else              begin rk = 2; rdst = m_own[l]; end
    if (!rd)
      for (int p = 0; p < NP; p++)
        if (m_sh[l][p] && p != s && !(rk == 2 && p == m_own[l])) begin
          exp_q.push_back(3 * 16 + p);
          tag_q.push_back("R8");
        end
    if (rd) t = m_hv[l] ? "R4" : "R11";
    else if (hit) t = "R6";
    else if (k == 2) t = "R7";
    else t = "R5";
    exp_q.push_back(rk * 16 + rdst);
    tag_q.push_back(t);
    if (rd) m_sh[l][s] = 1'b1;
    else begin
      m_sh[l] = '0;
      m_sh[l][s] = 1'b1;
      m_own[l] = s;
      m_hv[l] = 1'b0;
    end
  endtask

  task automatic do_req(input int k, input int s, input int l);
    int wd;
    bit was_stall;
    logic [2:0] sk, sd, sr;
    logic [5:0] sl;
    int e;
    string t;
    model(k, s, l);
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_kind  = 2'(k);
    req_src   = 3'(s);
    req_line  = 6'(l);
    @(negedge clk);
    req_valid = 1'b0;
    wd = 0;
    was_stall = 0;
    sk = '0; sd = '0; sr = '0; sl = '0;
    while (exp_q.size() > 0 && wd < 400) begin
      if (was_stall)
        chk(out_kind == sk && out_dst == sd && out_req == sr && out_line == sl,
            "R10", "fields held during stall", int'(out_dst), int'(sd));
      chk(out_valid == 1'b1 && req_ready == 1'b0, "R9", "busy window valid/ready",
          int'({out_valid, req_ready}), 2);
      out_ready = stall_en ? ($urandom_range(0, 2) != 0) : 1'b1;
      if (out_ready && out_valid) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(int'(out_kind) == e / 16, t, "message kind", int'(out_kind), e / 16);
        chk(int'(out_dst) == e % 16, t, "message destination", int'(out_dst), e % 16);
        chk(int'(out_req) == s && int'(out_line) == l, "R3", "requester/line fields",
            int'(out_req) * 64 + int'(out_line), s * 64 + l);
        was_stall = 0;
      end else begin
        was_stall = 1;
        sk = out_kind; sd = out_dst; sr = out_req; sl = out_line;
      end
      @(negedge clk);
      wd++;
    end
    out_ready = 1'b0;
    if (wd >= 400) begin
      chk(0, "R9", "transaction did not finish", exp_q.size(), 0);
      exp_q.delete();
      tag_q.delete();
    end
    chk(req_ready == 1'b1 && out_valid == 1'b0, "R9", "idle after final message",
        int'({req_ready, out_valid}), 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_sh[i] = '0;
      m_own[i] = 0;
      m_hv[i] = 1'b1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

    do_req(0, 2, 5);   // R1 R4: data from home
    do_req(0, 6, 5);   // R4
    do_req(2, 6, 5);   // R6: inv 2, grant 6
    do_req(0, 1, 5);   // R11: forward to owner 6
    do_req(0, 3, 5);   // R11: still forwarded
    do_req(1, 0, 5);   // R5: inv 1,3 then forward-exclusive to 6
    do_req(2, 4, 5);   // R7: non-sharer upgrade, forward-exclusive to 0
    do_req(0, 4, 5);   // R4: owner reads, grant
    do_req(1, 4, 5);   // R5: owner exclusive read, grant
    for (int p = 0; p < NP; p++) do_req(0, p, 9);
    stall_en = 1;
    do_req(2, 7, 9);   // R8 R10: seven invalidations with stalls
    do_req(3, 0, 9);   // R2: kind 3 as exclusive read
    do_req(1, 2, 63);  // R5: fresh line, data from home
    for (int p = 0; p < NP; p++) do_req(0, p, 20);
    do_req(1, 3, 20);  // R5 R8: inv all but 3, data reply
    for (int n = 0; n < 300; n++)
      do_req($urandom_range(0, 3), $urandom_range(0, NP - 1), $urandom_range(0, 3));
    stall_en = 0;
    for (int n = 0; n < 50; n++)
      do_req($urandom_range(0, 3), $urandom_range(0, NP - 1), $urandom_range(0, 1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule